// File: doc/BRIEF.md
# Serial Register Access Port

This block terminates a byte-oriented serial bus (chip enable, serial clock, data in, data out) in front of a small clock-and-calendar register file and a general-purpose RAM. Every transaction opens with one address byte. Its top bit chooses the direction: clear means read, set means write, and the lower seven bits name the location. Data bytes follow. In a burst the location steps forward after each byte and wraps inside its own region.

At the start of every read the block latches the live time and date bytes into a holding copy. A burst read therefore returns a consistent set while the counters keep running. Alarm, status and charger-setting locations are held by neighbouring blocks. The port reaches them through a plain register interface: a combinational read address and read data, and a one-cycle write strobe. The block itself holds the control byte, which carries the write-protect bit, and the RAM. It applies fixed-zero masks on both reads and writes, turns reserved locations into reads of zero, and drops any byte whose eighth bit never arrived.

The serial inputs are taken as already synchronous to `clk`. Edges of `sclk` are detected by comparing each sample with the previous one.

Top module: `serial_reg_port`

## Requirements
- R1: While `ce` is high, `mosi` is sampled on each rising `sclk` edge, most significant bit first. The first full byte is the address. Bit 7 set means write, and bits 6:0 give the location (00h–7Fh).
- R2: In a read, bit 7 of the first data byte appears on `miso` once the address byte completes. Each later bit appears after a falling `sclk` edge. `misoOe` is high only in the data phase of a read and drops as soon as `ce` goes low.
- R3: When a read's address byte completes, the seven live time bytes (locations 00h–06h, byte 0 on `liveTime[7:0]`) are copied. Reads of 00h–06h return that copy for the rest of the transaction.
- R4: In a burst, a location below 20h steps by one after each data byte and wraps from 1Fh to 00h.
- R5: 96 RAM bytes sit at 20h–7Fh. A burst in RAM wraps from 7Fh to 20h.
- R6: Locations 12h–1Fh read as 00h. Writes to them produce no write strobe and change nothing.
- R7: Fixed-zero bits read as 0 and are stored as 0. The masks are 00h–02h: 7Fh, 03h: 07h, 04h: 3Fh, 05h: 1Fh, 06h: FFh, 07h–09h and 0Bh–0Dh: FFh, 0Ah and 0Eh: 87h, 0Fh: C7h, 10h: 03h, 11h: FFh, RAM: FFh.
- R8: The control byte is at 0Fh and resets to 40h. Its bit 6 is write protect. While that bit is set, every write except a write to 0Fh is dropped.
- R9: Dropping `ce` clears the bit count and ends the burst. A byte cut short is not written, and the next transaction starts with an address byte.
- R10: A permitted write to 00h–0Eh, 10h or 11h gives one `extWrEn` cycle, carrying the location on `extWrAddr` and the masked byte on `extWrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ce | input | 1 | Chip enable, active high |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| misoOe | output | 1 | High while read data is driven |
| liveTime | input | 56 | Live time bytes, location n on bits 8n+7:8n |
| extRdAddr | output | 5 | Location whose byte is needed next |
| extRdData | input | 8 | Neighbour's byte for `extRdAddr` |
| extWrEn | output | 1 | One-cycle write strobe to neighbours |
| extWrAddr | output | 5 | Location being written |
| extWrData | output | 8 | Masked byte being written |
| ctrlOut | output | 8 | Current control byte |

## Verification
The main function is exercised with several traffic shapes. Single-byte writes show that masking and the protection gate apply per location. Bursts started near 1Fh and 7Fh show whether each region wraps into itself or spills into the other. A burst read during which the live time changes after the address byte separates a latched copy from a live path. A transaction aborted after five bits, followed by a fresh write, shows both that the partial byte is dropped and that the bit count restarts. Reads of reserved, alarm and RAM locations confirm that each region is decoded apart from the others.

// File: rtl/srac_pkg.sv
package srac_pkg;

  typedef struct packed {
    logic capAddr;   // address byte just completed
    logic commit;    // write data byte just completed
    logic advance;   // data byte done, step location
    logic loadTx;    // load next read byte into tx shifter
    logic shiftTx;   // present next read bit
    logic takeSnap;  // latch live time bytes
  } strobe_t;

  localparam logic [6:0] LOC_TIME_LAST = 7'h06;
  localparam logic [6:0] LOC_CTRL      = 7'h0F;
  localparam logic [6:0] LOC_LAST_REG  = 7'h11;
  localparam logic [7:0] CTRL_MASK     = 8'hC7;
  localparam int         WP_BIT        = 6;

  function automatic logic [7:0] regMask(input logic [4:0] loc);
    logic [7:0] m;
    case (loc)
      5'h00, 5'h01, 5'h02: m = 8'h7F;
      5'h03:               m = 8'h07;
      5'h04:               m = 8'h3F;
      5'h05:               m = 8'h1F;
      5'h06:               m = 8'hFF;
      5'h07, 5'h08, 5'h09,
      5'h0B, 5'h0C, 5'h0D: m = 8'hFF;
      5'h0A, 5'h0E:        m = 8'h87;
      5'h0F:               m = CTRL_MASK;
      5'h10:               m = 8'h03;
      5'h11:               m = 8'hFF;
      default:             m = 8'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/srac_ctrl.sv
module srac_ctrl
  import srac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ce,
  input  logic       sclk,
  input  logic       mosi,
  output strobe_t    stb,
  output logic [7:0] rxByte,
  output logic       readActive
);

  logic       sclkQ;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic       dataPhase;
  logic       isWrite;
  logic       riseEdge, fallEdge, byteDone;

  assign riseEdge = ce & sclk & ~sclkQ;
  assign fallEdge = ce & ~sclk & sclkQ;
  assign byteDone = riseEdge && (bitCnt == 3'd7);
  assign rxByte   = {shiftIn, mosi};

  always_comb begin
    stb          = '0;
    stb.capAddr  = byteDone & ~dataPhase;
    stb.commit   = byteDone & dataPhase & isWrite;
    stb.advance  = byteDone & dataPhase;
    stb.takeSnap = byteDone & ~dataPhase & ~rxByte[7];
    stb.loadTx   = byteDone & (dataPhase ? ~isWrite : ~rxByte[7]);
    stb.shiftTx  = fallEdge & dataPhase & ~isWrite & (bitCnt != 3'd0);
  end

  assign readActive = ce & dataPhase & ~isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      bitCnt    <= '0;
      shiftIn   <= '0;
      dataPhase <= 1'b0;
      isWrite   <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (!ce) begin
        bitCnt    <= '0;
        dataPhase <= 1'b0;
        isWrite   <= 1'b0;
      end else if (riseEdge) begin
        bitCnt  <= bitCnt + 3'd1;
        shiftIn <= {shiftIn[5:0], mosi};
        if (byteDone && !dataPhase) begin
          dataPhase <= 1'b1;
          isWrite   <= rxByte[7];
        end
      end
    end
  end

  // R9: chip enable low leaves no partial state behind
  p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> (bitCnt == 3'd0) && !dataPhase);

  // R1: the data phase opens only after eight bits of address
  p_addr_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataPhase) |-> ($past(bitCnt) == 3'd7) && $past(ce));

  // R2: output enable falls together with chip enable
  p_oe_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ce |-> !readActive);

endmodule

// File: rtl/srac_ram.sv
module srac_ram #(
  parameter int DEPTH = 96,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wIdx,
  input  logic [7:0]       wData,
  input  logic [IDX_W-1:0] rIdx,
  output logic [7:0]       rData
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wIdx] <= wData;
  end

  assign rData = mem[rIdx];

endmodule

// File: rtl/srac_dp.sv
module srac_dp
  import srac_pkg::*;
#(
  parameter int         ADDR_W     = 7,
  parameter int         CLK_SPAN   = 32,
  parameter int         TIME_BYTES = 7,
  parameter logic [7:0] CTRL_RESET = 8'h40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [7:0]              rxByte,
  input  logic                    readActive,
  input  logic [TIME_BYTES*8-1:0] liveTime,
  output logic                    miso,
  output logic [4:0]              extRdAddr,
  input  logic [7:0]              extRdData,
  output logic                    extWrEn,
  output logic [4:0]              extWrAddr,
  output logic [7:0]              extWrData,
  output logic [7:0]              ctrlOut
);

  localparam int RAM_BYTES = (1 << ADDR_W) - CLK_SPAN;
  localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(CLK_SPAN);
  localparam logic [ADDR_W-1:0] CLK_TOP  = ADDR_W'(CLK_SPAN - 1);

  logic [ADDR_W-1:0]       addrQ, rdAddr, rdOff, wrOff;
  logic [7:0]              txQ, ctrlQ, rawRd, rdByte, ramRd;
  logic [TIME_BYTES*8-1:0] snap;
  logic                    permit, ramWe;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a);
    if (a < RAM_BASE) return (a == CLK_TOP) ? '0 : a + 1'b1;
    return (a == '1) ? RAM_BASE : a + 1'b1;
  endfunction

  // ---- read path: location for the byte about to be loaded
  assign rdAddr    = stb.capAddr ? rxByte[ADDR_W-1:0] : stepAddr(addrQ);
  assign extRdAddr = rdAddr[4:0];
  assign rdOff     = (rdAddr >= RAM_BASE) ? rdAddr - RAM_BASE : '0;

  always_comb begin
    rawRd = 8'h00;
    if (rdAddr >= RAM_BASE)
      rawRd = ramRd;
    else if (rdAddr <= LOC_TIME_LAST)
      rawRd = stb.takeSnap ? liveTime[int'(rdAddr)*8 +: 8] : snap[int'(rdAddr)*8 +: 8];
    else if (rdAddr == LOC_CTRL)
      rawRd = ctrlQ;
    else if (rdAddr <= LOC_LAST_REG)
      rawRd = extRdData;
    rdByte = rawRd & ((rdAddr >= RAM_BASE) ? 8'hFF : regMask(rdAddr[4:0]));
  end

  // ---- write path with protection gate
  assign permit    = stb.commit && (addrQ == LOC_CTRL || !ctrlQ[WP_BIT]);
  assign ramWe     = permit && (addrQ >= RAM_BASE);
  assign wrOff     = (addrQ >= RAM_BASE) ? addrQ - RAM_BASE : '0;
  assign extWrEn   = permit && (addrQ <= LOC_LAST_REG) && (addrQ != LOC_CTRL);
  assign extWrAddr = addrQ[4:0];
  assign extWrData = rxByte & regMask(addrQ[4:0]);
  assign ctrlOut   = ctrlQ;
  assign miso      = readActive & txQ[7];

  srac_ram #(.DEPTH(RAM_BYTES), .IDX_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ramWe),
    .wIdx  (wrOff),
    .wData (rxByte),
    .rIdx  (rdOff),
    .rData (ramRd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      txQ   <= '0;
      ctrlQ <= CTRL_RESET & CTRL_MASK;
    end else begin
      if (stb.capAddr)      addrQ <= rxByte[ADDR_W-1:0];
      else if (stb.advance) addrQ <= stepAddr(addrQ);
      if (stb.loadTx)       txQ <= rdByte;
      else if (stb.shiftTx) txQ <= {txQ[6:0], 1'b0};
      if (stb.commit && addrQ == LOC_CTRL) ctrlQ <= rxByte & CTRL_MASK;
    end
  end

  // snapshot bytes, one register per time location
  for (genvar g = 0; g < TIME_BYTES; g++) begin : g_snap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             snap[g*8 +: 8] <= '0;
      else if (stb.takeSnap) snap[g*8 +: 8] <= liveTime[g*8 +: 8];
    end
  end

  // R3: the held copy changes only when a read begins
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.takeSnap |=> $stable(snap));

  // R8: no strobe leaves while protection is on
  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    extWrEn |-> !ctrlQ[WP_BIT]);

  // R6: reserved and local locations never reach the neighbours
  p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    extWrEn |-> (extWrAddr <= 5'h11) && (extWrAddr != 5'h0F));

  // R4: a clock-region burst stays in the clock region
  p_clk_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && addrQ < RAM_BASE) |=> addrQ < RAM_BASE);

  // R5: a RAM burst stays in RAM
  p_ram_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && addrQ >= RAM_BASE) |=> addrQ >= RAM_BASE);

  // R10: one strobe per completed byte
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    extWrEn |=> !extWrEn);

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srac_pkg::*;
#(
  parameter int         ADDR_W     = 7,
  parameter int         CLK_SPAN   = 32,
  parameter int         TIME_BYTES = 7,
  parameter logic [7:0] CTRL_RESET = 8'h40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ce,
  input  logic                    sclk,
  input  logic                    mosi,
  output logic                    miso,
  output logic                    misoOe,
  input  logic [TIME_BYTES*8-1:0] liveTime,
  output logic [4:0]              extRdAddr,
  input  logic [7:0]              extRdData,
  output logic                    extWrEn,
  output logic [4:0]              extWrAddr,
  output logic [7:0]              extWrData,
  output logic [7:0]              ctrlOut
);

  strobe_t    stb;
  logic [7:0] rxByte;
  logic       readActive;

  srac_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ce         (ce),
    .sclk       (sclk),
    .mosi       (mosi),
    .stb        (stb),
    .rxByte     (rxByte),
    .readActive (readActive)
  );

  srac_dp #(
    .ADDR_W     (ADDR_W),
    .CLK_SPAN   (CLK_SPAN),
    .TIME_BYTES (TIME_BYTES),
    .CTRL_RESET (CTRL_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rxByte     (rxByte),
    .readActive (readActive),
    .liveTime   (liveTime),
    .miso       (miso),
    .extRdAddr  (extRdAddr),
    .extRdData  (extRdData),
    .extWrEn    (extWrEn),
    .extWrAddr  (extWrAddr),
    .extWrData  (extWrData),
    .ctrlOut    (ctrlOut)
  );

  assign misoOe = readActive;

endmodule

// File: tb/serial_reg_port_bench.sv
module serial_reg_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ce = 1'b0, sclk = 1'b0, mosi = 1'b0;
  logic        miso, misoOe, extWrEn;
  logic [55:0] liveTime;
  logic [4:0]  extRdAddr, extWrAddr;
  logic [7:0]  extRdData, extWrData, ctrlOut;

  int nChecks = 0;
  int nFail   = 0;
  int extWrCount = 0;
  int expWrCount = 0;
  logic [7:0] extModel [32];
  logic [7:0] rdBuf [8];

  always #2 clk = ~clk;  // 250 MHz

  serial_reg_port u_serial_reg_port (
    .clk(clk), .rstN(rstN), .ce(ce), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .liveTime(liveTime),
    .extRdAddr(extRdAddr), .extRdData(extRdData),
    .extWrEn(extWrEn), .extWrAddr(extWrAddr), .extWrData(extWrData),
    .ctrlOut(ctrlOut)
  );

  // neighbour register file modelled behaviourally
  assign extRdData = extModel[extRdAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) extModel[i] <= 8'h00;
    end else if (extWrEn) begin
      extModel[extWrAddr] <= extWrData;
      extWrCount <= extWrCount + 1;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBit(input logic b, output logic got);
    sclk = 1'b0; mosi = b;
    waitN(2);
    got = miso;
    sclk = 1'b1;
    waitN(2);
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      xferBit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic openTx();
    sclk = 1'b0; waitN(1); ce = 1'b1; waitN(1);
  endtask

  task automatic closeTx();
    sclk = 1'b0; waitN(2); ce = 1'b0; waitN(2);
  endtask

  task automatic wrBurst(input logic [6:0] a, input logic [7:0] d [4], input int n);
    logic [7:0] dummy;
    openTx();
    xferByte({1'b1, a}, dummy);
    for (int i = 0; i < n; i++) xferByte(d[i], dummy);
    closeTx();
  endtask

  task automatic rdBurst(input logic [6:0] a, input int n, input logic zapLive);
    logic [7:0] dummy;
    openTx();
    xferByte({1'b0, a}, dummy);
    if (zapLive) liveTime = '0;
    for (int i = 0; i < n; i++) xferByte(8'h00, rdBuf[i]);
    closeTx();
  endtask

  localparam logic [55:0] LIVE_A = {8'h24, 8'hE2, 8'hF1, 8'hFB, 8'hF2, 8'hB7, 8'hD9};

  initial begin
    logic [7:0] dummy;
    logic b;
    liveTime = LIVE_A;
    waitN(5);
    rstN = 1'b1;
    waitN(2);

    // reset state
    chk(ctrlOut, 8'h40, "R8 control reset value");
    chk({7'd0, misoOe}, 8'h00, "R2 oe low after reset");

    // protected write to seconds is dropped
    wrBurst(7'h00, '{8'h12, 8'h00, 8'h00, 8'h00}, 1);
    chk(8'(extWrCount), 8'(expWrCount), "R8 no strobe while protected");

    // control stays writable, masks to C7h
    wrBurst(7'h0F, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1);
    chk(ctrlOut, 8'hC7, "R7 control fixed zeros");
    wrBurst(7'h0F, '{8'h00, 8'h00, 8'h00, 8'h00}, 1);
    chk(ctrlOut, 8'h00, "R8 protect cleared while set");

    // neighbour write with mask
    wrBurst(7'h00, '{8'hD9, 8'h00, 8'h00, 8'h00}, 1);
    expWrCount++;
    chk(8'(extWrCount), 8'(expWrCount), "R10 one strobe per byte");
    chk(extModel[0], 8'h59, "R10 masked seconds written");
    wrBurst(7'h0A, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1);
    expWrCount++;
    chk(extModel[10], 8'h87, "R7 day alarm mask");
    rdBurst(7'h0A, 1, 1'b0);
    chk(rdBuf[0], 8'h87, "R1 read of alarm location");

    // coherent burst read while live time changes
    liveTime = LIVE_A;
    rdBurst(7'h00, 7, 1'b1);
    chk(rdBuf[0], 8'h59, "R3 snap seconds");
    chk(rdBuf[1], 8'h37, "R3 snap minutes");
    chk(rdBuf[2], 8'h72, "R3 snap hours");
    chk(rdBuf[3], 8'h03, "R7 day masked");
    chk(rdBuf[4], 8'h31, "R3 snap date");
    chk(rdBuf[5], 8'h02, "R7 month masked");
    chk(rdBuf[6], 8'h24, "R3 snap year");

    // clock region wrap 1F -> 00
    liveTime = LIVE_A;
    rdBurst(7'h1E, 4, 1'b0);
    chk(rdBuf[0], 8'h00, "R6 reserved 1E reads zero");
    chk(rdBuf[1], 8'h00, "R6 reserved 1F reads zero");
    chk(rdBuf[2], 8'h59, "R4 wrap to 00");
    chk(rdBuf[3], 8'h37, "R4 then 01");

    // reserved write ignored
    wrBurst(7'h12, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1);
    chk(8'(extWrCount), 8'(expWrCount), "R6 reserved write no strobe");
    rdBurst(7'h12, 1, 1'b0);
    chk(rdBuf[0], 8'h00, "R6 reserved reads zero");

    // RAM wrap 7F -> 20
    wrBurst(7'h7F, '{8'hA5, 8'h5A, 8'h3C, 8'h00}, 3);
    rdBurst(7'h7F, 3, 1'b0);
    chk(rdBuf[0], 8'hA5, "R5 RAM 7F");
    chk(rdBuf[1], 8'h5A, "R5 wrap to 20");
    chk(rdBuf[2], 8'h3C, "R5 then 21");

    // partial byte dropped, next transaction restarts at address
    openTx();
    xferByte(8'hA1, dummy);
    for (int i = 0; i < 5; i++) xferBit(1'b1, b);
    closeTx();
    rdBurst(7'h21, 1, 1'b0);
    chk(rdBuf[0], 8'h3C, "R9 cut byte not written");
    wrBurst(7'h22, '{8'h77, 8'h00, 8'h00, 8'h00}, 1);
    rdBurst(7'h22, 1, 1'b0);
    chk(rdBuf[0], 8'h77, "R9 fresh address after abort");

    // protection also covers RAM and neighbours
    wrBurst(7'h0F, '{8'h40, 8'h00, 8'h00, 8'h00}, 1);
    wrBurst(7'h20, '{8'h00, 8'h00, 8'h00, 8'h00}, 1);
    wrBurst(7'h01, '{8'h11, 8'h00, 8'h00, 8'h00}, 1);
    rdBurst(7'h20, 1, 1'b0);
    chk(rdBuf[0], 8'h5A, "R8 RAM write blocked");
    chk(8'(extWrCount), 8'(expWrCount), "R8 neighbour write blocked");

    // output enable behaviour
    openTx();
    xferByte(8'hA0, dummy);
    chk({7'd0, misoOe}, 8'h00, "R2 oe low in write");
    closeTx();
    openTx();
    for (int i = 0; i < 4; i++) xferBit(1'b0, b);
    chk({7'd0, misoOe}, 8'h00, "R2 oe low during address");
    for (int i = 0; i < 4; i++) xferBit(i == 3, b);
    chk({7'd0, misoOe}, 8'h01, "R2 oe high in read data");
    closeTx();
    chk({7'd0, misoOe}, 8'h00, "R2 oe low after ce");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule